// File: doc/BRIEF.md
# Bus Wait-State Generator with Released Ready Line

This block slows the processor down for accesses to slow regions of a 16-bit address space with a 4-bit bank extension. It adds exactly one wait state. It sits beside the processor on a shared ready line that has an external pullup and that the processor itself may pull low. The address, the bank bits and the two valid-address qualifiers (data-valid and program-valid) are presented during the low phase of the bus clock. The block samples them at the rising edge that ends that phase and also captures the bank bits for the rest of the system.

A slow access is one with at least one qualifier high, a bank of zero, and an address in 0xC000–0xCFFF, 0xD000–0xD7FF or 0xE000–0xFFFF. On such an access the block first drives the ready line low, so the processor stalls on the next falling edge. One cycle later it drives the line high for half a clock. It then releases the line. At every other time the pin is released, and the external pullup holds it high. Because of this, the processor can pull ready low itself, for example while it waits for an interrupt with no valid address, and no two drivers ever fight over the line. The pin is exposed as a drive value and an output enable.

Top module: `wait_ready_gen`

## Requirements
- R1: A wait state starts only on a rising edge at which `data_valid_i` or `prog_valid_i` is high. With both low, an access at a slow address gets no stall.
- R2: `bank_o` takes the value of `bank_i` at each rising clock edge and holds it until the next rising edge.
- R3: An access is slow when `bank_i` is 0 and `addr_i` lies in 0xC000–0xCFFF, 0xD000–0xD7FF or 0xE000–0xFFFF. Any other qualified access sees zero stall cycles.
- R4: After the rising edge that samples a slow access, `rdy_oe_o` is 1 and `rdy_drive_o` is 0 through the following high phase, so ready is low at the next falling edge.
- R5: At the next rising edge `rdy_drive_o` becomes 1 while `rdy_oe_o` stays 1. Each slow access therefore sees exactly one stall cycle.
- R6: At the falling edge after the drive-high phase, `rdy_oe_o` returns to 0. The drive-high interval lasts one half clock.
- R7: While the processor pulls ready low and both qualifiers are low, `rdy_oe_o` stays 0, so a driven high never meets the pull-down. Once the pull-down is removed, the pullup restores ready high.
- R8: Back-to-back slow accesses each receive exactly one stall. The first falling edge of the second access sees ready driven low.
- R9: An active-low asynchronous `rst_ni` clears the sequence and the bank capture. It forces `rdy_oe_o` to 0 and `bank_o` to 0 immediately, even in the middle of a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; address valid while low |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Address within the bank |
| bank_i | input | 4 | Upper bank bits |
| data_valid_i | input | 1 | Data-address valid qualifier |
| prog_valid_i | input | 1 | Program-address valid qualifier |
| bank_o | output | 4 | Bank bits captured at the rising edge |
| rdy_drive_o | output | 1 | Value put on the ready pin when enabled |
| rdy_oe_o | output | 1 | Ready pin output enable; 0 means released |

## Verification
The bench probes every region boundary (0xBFFF/0xC000, 0xCFFF/0xD000, 0xD7FF/0xD800, 0xDFFF/0xE000, 0xFFFF) and a slow address in a nonzero bank. An off-by-one mask or a missing bank check shows up there as a stray stall or a missing stall. Back-to-back slow accesses catch a sequencer that ignores the second request or lets the pin float high for its first falling edge, either of which gives zero stalls. A processor pull-down with both qualifiers low, and with the address still in a slow region, exposes a design that starts a wait anyway and then drives high into the pull-down. A resolved-pin monitor flags any drive-high phase that outlasts half a clock. It also flags a driven high that coincides with the processor's pull-down.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned BANK_W   = 4;
  localparam int unsigned NUM_SLOW = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
  } region_t;

  // aligned regions: hit when (addr & mask) == base
  localparam region_t SLOW_MAP [NUM_SLOW] = '{
    '{base: 16'hC000, mask: 16'hF000},
    '{base: 16'hD000, mask: 16'hF800},
    '{base: 16'hE000, mask: 16'hE000}
  };
endpackage

// File: rtl/ws_decode.sv
module ws_decode
  import ws_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              valid_i,
  output logic              slow_o
);
  logic [NUM_SLOW-1:0] hit;

  for (genvar g = 0; g < NUM_SLOW; g++) begin : g_rgn
    assign hit[g] = (addr_i & SLOW_MAP[g].mask) == SLOW_MAP[g].base;
  end

  assign slow_o = valid_i && (bank_i == '0) && (|hit);
endmodule

// File: rtl/ws_bank_latch.sv
module ws_bank_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bank_i,
  output logic [W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_o <= '0;
    else         bank_o <= bank_i;
  end

  p_bank_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (bank_o == $past(bank_i)));
endmodule

// File: rtl/ws_seq.sv
module ws_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rdy_drive_o,
  output logic rdy_oe_o
);
  // rising-edge stage: wait pending and drive-high flop
  logic wait_q, hi_q;
  // falling-edge stage: arm drive-high, release pin
  logic mid_q, rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      hi_q   <= 1'b0;
    end else if (!wait_q || rel_q) begin
      // idle or sequence finished: accept a new request
      wait_q <= start_i;
      hi_q   <= 1'b0;
    end else begin
      hi_q   <= mid_q;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      mid_q <= wait_q & ~hi_q;
      rel_q <= wait_q & hi_q;
    end
  end

  assign rdy_oe_o    = wait_q & ~(rel_q & hi_q);
  assign rdy_drive_o = hi_q;

  p_high_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && !rel_q && !hi_q) |=> hi_q);

  p_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_q |-> !rdy_oe_o);

  p_low_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_oe_o && start_i) |=> (rdy_oe_o && !rdy_drive_o));
endmodule

// File: rtl/wait_ready_gen.sv
module wait_ready_gen
  import ws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              data_valid_i,
  input  logic              prog_valid_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              rdy_drive_o,
  output logic              rdy_oe_o
);
  logic addr_valid;
  logic slow;

  assign addr_valid = data_valid_i | prog_valid_i;

  ws_decode i_decode (
    .addr_i  (addr_i),
    .bank_i  (bank_i),
    .valid_i (addr_valid),
    .slow_o  (slow)
  );

  ws_bank_latch #(.W(BANK_W)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bank_i (bank_i),
    .bank_o (bank_o)
  );

  ws_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (slow),
    .rdy_drive_o (rdy_drive_o),
    .rdy_oe_o    (rdy_oe_o)
  );

  p_no_wait_unqualified_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_oe_o && !addr_valid) |=> !rdy_oe_o);

  p_fast_no_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_oe_o && !slow) |=> !rdy_oe_o);

  p_reset_release_r9: assert property (@(negedge clk_i)
    !rst_ni |-> !rdy_oe_o);
endmodule

// File: tb/test_wait_ready_gen.sv
module test_wait_ready_gen;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] addr;
  logic [3:0]  bank;
  logic        dv, pv;
  logic        cpu_pull;
  logic [3:0]  bank_o;
  logic        rdy_drive_o, rdy_oe_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wait_ready_gen i_wait_ready_gen (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .addr_i       (addr),
    .bank_i       (bank),
    .data_valid_i (dv),
    .prog_valid_i (pv),
    .bank_o       (bank_o),
    .rdy_drive_o  (rdy_drive_o),
    .rdy_oe_o     (rdy_oe_o)
  );

  function automatic bit exp_slow(logic [15:0] a, logic [3:0] b, bit d, bit p);
    bit in_rgn;
    in_rgn = (a >= 16'hC000 && a <= 16'hCFFF) || (a >= 16'hD000 && a <= 16'hD7FF) ||
             (a >= 16'hE000);
    return (d || p) && (b == 4'h0) && in_rgn;
  endfunction

  // resolved pin: block driver, else processor pull-down, else pullup
  function automatic bit rdy_pin();
    if (rdy_oe_o) return rdy_drive_o;
    return !cpu_pull;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic access(logic [15:0] a, logic [3:0] b, bit d, bit p, string tag);
    int stalls;
    bit e;
    @(negedge clk);
    addr = a; bank = b; dv = d; pv = p;
    e = exp_slow(a, b, d, p);
    stalls = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      if (k == 0) chk(bank_o == b, "R2 bank capture", bank_o, b);
      if (rdy_pin()) break;
      if (stalls == 0) chk(rdy_oe_o && !rdy_drive_o, "R4 driven low", {rdy_oe_o, rdy_drive_o}, 2);
      stalls++;
    end
    if (stalls > 0) chk(rdy_oe_o && rdy_drive_o, "R5 driven high", {rdy_oe_o, rdy_drive_o}, 3);
    chk(stalls == (e ? 1 : 0), tag, stalls, e ? 1 : 0);
  endtask

  // R6 / R7 monitor: drive-high lasts half a clock, never meets a pull-down
  initial begin
    bit hi_seen;
    forever begin
      @(posedge clk); #1;
      hi_seen = rdy_oe_o && rdy_drive_o;
      if (rdy_oe_o && rdy_drive_o && cpu_pull) chk(1'b0, "R7 contention", 1, 0);
      @(negedge clk); #1;
      if (hi_seen) chk(!rdy_oe_o, "R6 release after high", rdy_oe_o, 0);
      if (rdy_oe_o && rdy_drive_o && cpu_pull) chk(1'b0, "R7 contention", 1, 0);
    end
  end

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0C1D));
    rst_ni = 1'b0; cpu_pull = 1'b0;
    addr = 16'hE000; bank = 4'h0; dv = 1'b1; pv = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rdy_oe_o, "R9 reset oe", rdy_oe_o, 0);
    chk(bank_o == 4'h0, "R9 reset bank", bank_o, 0);
    @(negedge clk);
    dv = 1'b0;
    rst_ni = 1'b1;

    // region boundaries
    access(16'hBFFF, 4'h0, 1, 0, "R3 below C000");
    access(16'hC000, 4'h0, 1, 0, "R3 C000");
    access(16'hCFFF, 4'h0, 0, 1, "R3 CFFF");
    access(16'hD000, 4'h0, 1, 0, "R3 D000");
    access(16'hD7FF, 4'h0, 1, 0, "R3 D7FF");
    access(16'hD800, 4'h0, 1, 0, "R3 D800");
    access(16'hDFFF, 4'h0, 0, 1, "R3 DFFF");
    access(16'hE000, 4'h0, 1, 0, "R3 E000");
    access(16'hFFFF, 4'h0, 1, 1, "R3 FFFF");
    access(16'h0000, 4'h0, 1, 0, "R3 0000");
    access(16'hC000, 4'h1, 1, 0, "R3 nonzero bank");
    access(16'hE123, 4'h8, 0, 1, "R3 nonzero bank high");
    // qualifiers
    access(16'hC100, 4'h0, 0, 0, "R1 no qualifier");
    access(16'hF000, 4'h0, 0, 1, "R1 program qualifier");
    access(16'hD100, 4'h0, 1, 0, "R1 data qualifier");
    // back-to-back
    access(16'hE000, 4'h0, 1, 0, "R8 first");
    access(16'hC004, 4'h0, 1, 0, "R8 second");
    access(16'hD004, 4'h0, 0, 1, "R8 third");

    // processor pull-down with no valid address, pc still in slow region
    @(negedge clk);
    addr = 16'hE010; bank = 4'h0; dv = 1'b0; pv = 1'b0; cpu_pull = 1'b1;
    repeat (4) begin
      @(posedge clk); #1;
      chk(!rdy_oe_o, "R7 no enable while pulled", rdy_oe_o, 0);
      chk(rdy_pin() == 1'b0, "R7 line low", rdy_pin(), 0);
    end
    @(negedge clk);
    cpu_pull = 1'b0;
    @(posedge clk); #1;
    chk(rdy_pin() && !rdy_oe_o, "R7 pullup restores", rdy_pin(), 1);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      logic [3:0]  b;
      a = 16'($urandom_range(16'hFFFF, 16'hA000));
      b = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(15, 0)) : 4'h0;
      access(a, b, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), "R3 random");
    end

    // asynchronous reset mid-wait
    @(negedge clk);
    addr = 16'hC000; bank = 4'h0; dv = 1'b1; pv = 1'b0;
    @(posedge clk); #1;
    chk(rdy_oe_o && !rdy_drive_o, "R4 before reset", rdy_oe_o, 1);
    rst_ni = 1'b0;
    #0.5;
    chk(!rdy_oe_o, "R9 async reset oe", rdy_oe_o, 0);
    chk(bank_o == 4'h0, "R9 async reset bank", bank_o, 0);
    @(negedge clk);
    dv = 1'b0;
    rst_ni = 1'b1;
    access(16'hE000, 4'h0, 1, 0, "R8 after reset");

    finish_run();
  end
endmodule